// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the pending, in-service and trigger-kind state for 256 interrupt vectors. It derives a running processor priority from a software-written task priority and the highest vector now in service. It drives a level interrupt line whenever the best waiting request outranks that priority. Priority is judged by class: the upper four bits of the vector number. A larger vector number always wins.

A processor accepts an interrupt by pulsing an acknowledge strobe. One cycle later the block returns either the winning vector, which it moves from pending to in service, or a spurious vector with a flag and no state change. Writing the end-of-interrupt strobe retires the highest in-service vector. For a level-kind vector, unless broadcast suppression is set, it also emits a one-cycle broadcast carrying that vector number. Requests arrive on a valid/ready port. Ready is held high out of reset, so a request is taken on every cycle that valid is high and there is never back-pressure. A small write port loads the task priority and the enable/spurious register.

Top module: `vec_irq_prio`

## Requirements
- R1: Each request accepted (req_valid high; req_ready is always high after reset) sets the pending bit of req_vec from the next clock edge, and several vectors can be pending at once.
- R2: ppr_out equals the task priority when its bits 7:4 are at least the class of the highest in-service vector. Otherwise it equals that class followed by four zero bits. An empty in-service set counts as vector 0.
- R3: When enable bit 8 of the spurious register is clear, irq_out stays low and every acknowledge returns ack_spur=1.
- R4: If ppr_out is nonzero and the highest pending class is less than or equal to the ppr_out class, the request is blocked. irq_out is low, and an acknowledge returns ack_spur=1 with ack_vec equal to spurious register bits 7:0 and changes no state.
- R5: An acknowledge that is not blocked gives ack_valid=1, ack_spur=0 and ack_vec equal to the highest pending vector in the next cycle. It also clears that vector's pending bit and sets its in-service bit.
- R6: A request with req_level=1 sets the vector's trigger bit, and one with req_level=0 clears it. The latest request for a vector decides.
- R7: eoi_wr clears the highest in-service bit. In the next cycle bcast_valid pulses with bcast_vec set to that vector, but only if its trigger bit is set and suppress bit 12 of the spurious register is clear.
- R8: A write with wr_sel=1 keeps wr_data bits 8:0 (bits 7:0 are the spurious vector, bit 8 is enable) and bit 12 (suppress), and drops the rest. A write with wr_sel=0 loads the task priority from wr_data bits 7:0.
- R9: irq_out is decoded from registered state. It changes at the clock edge that changes the state.
- R10: eoi_wr with an empty in-service set changes nothing and gives no broadcast.
- R11: After reset all three vector sets are empty, the task priority is 0, and the spurious register is 0x0FF (disabled, vector 0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high after reset |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level kind, 0 = edge kind |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = task priority, 1 = spurious/enable |
| wr_data | input | 16 | Write data |
| ack_req | input | 1 | Acknowledge strobe |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Interrupt line |
| ppr_out | output | 8 | Processor priority |
| ack_valid | output | 1 | Acknowledge result present |
| ack_vec | output | 8 | Acknowledged or spurious vector |
| ack_spur | output | 1 | Result is spurious |
| bcast_valid | output | 1 | End-of-interrupt broadcast pulse |
| bcast_vec | output | 8 | Broadcast vector |

## Verification
Every cycle the assertions check several properties. The interrupt line never rises while the block is disabled. The processor priority never falls below the task priority. An accepted vector shows up as in service, and a spurious acknowledge leaves pending state untouched. Trigger bits follow the latest request, and a broadcast only ever carries a level-kind vector while suppression is clear. The directed scenarios and a random sequence checked against a reference model are what show which vector wins, how the priority moves through nested service and retirement, and which spurious vector value comes back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int VEC_W       = 8;
  localparam int SVR_EN_BIT  = 8;
  localparam int SUPPR_BIT   = 12;
  localparam logic [8:0] SVR_RESET = 9'h0FF;
  typedef logic [VEC_W-1:0] vec_t;
  typedef enum logic { SEL_TPR = 1'b0, SEL_SVR = 1'b1 } wsel_e;
endpackage

// File: rtl/irqc_hi_find.sv
// Highest-set-bit finder, split into words so each word resolves in parallel.
module irqc_hi_find #(
  parameter int N      = 256,
  parameter int WORD_W = 32
) (
  input  logic [N-1:0]         bits,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int NW = N / WORD_W;
  localparam int IW = $clog2(N);
  localparam int LW = $clog2(WORD_W);

  logic [NW-1:0] w_any;
  logic [LW-1:0] w_idx [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic          hit;
    logic [LW-1:0] pos;
    always_comb begin
      hit = |bits[w*WORD_W +: WORD_W];
      pos = '0;
      for (int b = 0; b < WORD_W; b++)
        if (bits[w*WORD_W + b]) pos = LW'(b);
    end
    assign w_any[w] = hit;
    assign w_idx[w] = pos;
  end

  always_comb begin
    any = |w_any;
    idx = '0;
    for (int w = 0; w < NW; w++)
      if (w_any[w]) idx = IW'(w * WORD_W) | IW'(w_idx[w]);
  end
endmodule

// File: rtl/irqc_prio.sv
// Processor priority and class-based gating of the best pending request.
module irqc_prio
  import irqc_pkg::*;
(
  input  vec_t tpr,
  input  logic isr_any,
  input  vec_t isr_hi,
  input  logic irr_any,
  input  vec_t irr_hi,
  input  logic enabled,
  output vec_t ppr,
  output logic deliver
);
  localparam int CW = VEC_W / 2;
  vec_t isr_v;
  logic blocked;

  always_comb begin
    isr_v   = isr_any ? isr_hi : '0;
    ppr     = (tpr[VEC_W-1:CW] >= isr_v[VEC_W-1:CW]) ? tpr : {isr_v[VEC_W-1:CW], {CW{1'b0}}};
    blocked = (ppr != '0) && (irr_hi[VEC_W-1:CW] <= ppr[VEC_W-1:CW]);
    deliver = enabled && irr_any && !blocked;
  end
endmodule

// File: rtl/vec_irq_prio.sv
module vec_irq_prio
  import irqc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_vec,
  input  logic        req_level,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        ack_req,
  input  logic        eoi_wr,
  output logic        irq_out,
  output logic [7:0]  ppr_out,
  output logic        ack_valid,
  output logic [7:0]  ack_vec,
  output logic        ack_spur,
  output logic        bcast_valid,
  output logic [7:0]  bcast_vec
);
  localparam int NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
  vec_t               tpr_q;
  logic [8:0]         svr_q;
  logic               suppr_q;

  logic irr_any, isr_any, deliver;
  vec_t irr_hi, isr_hi, ppr;

  irqc_hi_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_irr_find (
    .bits(irr_q), .any(irr_any), .idx(irr_hi));
  irqc_hi_find #(.N(NUM_VEC), .WORD_W(WORD_W)) u_isr_find (
    .bits(isr_q), .any(isr_any), .idx(isr_hi));

  irqc_prio u_prio (
    .tpr(tpr_q), .isr_any(isr_any), .isr_hi(isr_hi),
    .irr_any(irr_any), .irr_hi(irr_hi),
    .enabled(svr_q[SVR_EN_BIT]), .ppr(ppr), .deliver(deliver));

  // Retire first, then accept, then new requests: later steps win on a shared bit.
  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (eoi_wr && isr_any) isr_n[isr_hi] = 1'b0;
    if (ack_req && deliver) begin
      irr_n[irr_hi] = 1'b0;
      isr_n[irr_hi] = 1'b1;
    end
    if (req_valid) begin
      irr_n[req_vec] = 1'b1;
      tmr_n[req_vec] = req_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q       <= '0;
      isr_q       <= '0;
      tmr_q       <= '0;
      tpr_q       <= '0;
      svr_q       <= SVR_RESET;
      suppr_q     <= 1'b0;
      ack_valid   <= 1'b0;
      ack_vec     <= '0;
      ack_spur    <= 1'b0;
      bcast_valid <= 1'b0;
      bcast_vec   <= '0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
      if (wr_en) begin
        if (wsel_e'(wr_sel) == SEL_SVR) begin
          svr_q   <= wr_data[8:0];
          suppr_q <= wr_data[SUPPR_BIT];
        end else begin
          tpr_q <= wr_data[VEC_W-1:0];
        end
      end
      ack_valid   <= ack_req;
      ack_vec     <= deliver ? irr_hi : svr_q[VEC_W-1:0];
      ack_spur    <= !deliver;
      bcast_valid <= eoi_wr && isr_any && tmr_q[isr_hi] && !suppr_q;
      bcast_vec   <= isr_hi;
    end
  end

  assign req_ready = rst_n;
  assign irq_out   = deliver;
  assign ppr_out   = ppr;
endmodule

// File: rtl/vec_irq_prio_chk.sv
module vec_irq_prio_chk #(
  parameter int NUM_VEC = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [7:0]         req_vec,
  input logic               req_level,
  input logic               wr_en,
  input logic               wr_sel,
  input logic [15:0]        wr_data,
  input logic               eoi_wr,
  input logic               irq_out,
  input logic [7:0]         ppr_out,
  input logic               ack_valid,
  input logic [7:0]         ack_vec,
  input logic               ack_spur,
  input logic               bcast_valid,
  input logic [7:0]         bcast_vec,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q,
  input logic [NUM_VEC-1:0] tmr_q,
  input logic [7:0]         tpr_q,
  input logic [8:0]         svr_q,
  input logic               suppr_q
);
  logic [NUM_VEC-1:0] tmr_d;
  logic               suppr_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_d   <= '0;
      suppr_d <= 1'b0;
    end else begin
      tmr_d   <= tmr_q;
      suppr_d <= suppr_q;
    end
  end

  p_irq_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> svr_q[8]);
  p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_out >= tpr_q);
  p_ack_in_service_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_spur) |-> isr_q[ack_vec]);
  p_spur_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_spur && !$past(req_valid)) |-> $stable(irr_q));
  p_tmr_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (tmr_q[$past(req_vec)] == $past(req_level)));
  p_bcast_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> (tmr_d[bcast_vec] && !suppr_d));
  p_svr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (svr_q == $past(wr_data[8:0]) && suppr_q == $past(wr_data[12])));
  p_idle_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !(|isr_q)) |=> !bcast_valid);
endmodule

bind vec_irq_prio vec_irq_prio_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
  .req_level(req_level), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .eoi_wr(eoi_wr), .irq_out(irq_out), .ppr_out(ppr_out), .ack_valid(ack_valid),
  .ack_vec(ack_vec), .ack_spur(ack_spur), .bcast_valid(bcast_valid),
  .bcast_vec(bcast_vec), .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q),
  .tpr_q(tpr_q), .svr_q(svr_q), .suppr_q(suppr_q));

// File: tb/vec_irq_prio_test.sv
module vec_irq_prio_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_level = 1'b0;
  logic [7:0]  req_vec = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ack_req = 1'b0, eoi_wr = 1'b0;
  logic        req_ready, irq_out, ack_valid, ack_spur, bcast_valid;
  logic [7:0]  ppr_out, ack_vec, bcast_vec;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_irq_prio uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic do_req(input logic [7:0] v, input logic lvl);
    @(negedge clk); req_valid = 1'b1; req_vec = v; req_level = lvl;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic do_wr(input logic sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_ack(input string tag, input bit exp_spur, input int exp_vec);
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0;
    chk_eq({tag, " ack_valid"}, int'(ack_valid), 1);
    chk_eq({tag, " ack_spur"}, int'(ack_spur), int'(exp_spur));
    chk_eq({tag, " ack_vec"}, int'(ack_vec), exp_vec);
  endtask

  task automatic do_eoi(input string tag, input bit exp_b, input int exp_vec);
    @(negedge clk); eoi_wr = 1'b1;
    @(negedge clk); eoi_wr = 1'b0;
    chk_eq({tag, " bcast_valid"}, int'(bcast_valid), int'(exp_b));
    if (exp_b) chk_eq({tag, " bcast_vec"}, int'(bcast_vec), exp_vec);
  endtask

  task automatic t_reset();
    chk_eq("R11 irq after reset", int'(irq_out), 0);
    chk_eq("R11 ppr after reset", int'(ppr_out), 0);
    chk_eq("R1 req_ready", int'(req_ready), 1);
    do_ack("R11 empty ack", 1'b1, 8'hFF);
  endtask

  task automatic t_enable_and_nest();
    do_req(8'h45, 1'b1);
    chk_eq("R3 irq while disabled", int'(irq_out), 0);
    do_ack("R3 ack while disabled", 1'b1, 8'hFF);
    do_req(8'h80, 1'b0);
    do_req(8'h31, 1'b0);
    do_wr(1'b1, 16'h01FF);
    chk_eq("R9 irq after enable", int'(irq_out), 1);
    do_ack("R5 highest first", 1'b0, 8'h80);
    chk_eq("R2 ppr from in-service", int'(ppr_out), 8'h80);
    chk_eq("R4 lower class blocked", int'(irq_out), 0);
    do_ack("R4 blocked ack", 1'b1, 8'hFF);
    do_eoi("R7 edge no bcast", 1'b0, 0);
    chk_eq("R2 ppr after retire", int'(ppr_out), 0);
    chk_eq("R9 irq after retire", int'(irq_out), 1);
    do_ack("R5 next vector", 1'b0, 8'h45);
    chk_eq("R2 ppr class 4", int'(ppr_out), 8'h40);
    chk_eq("R4 class 3 blocked", int'(irq_out), 0);
    do_eoi("R7 level bcast", 1'b1, 8'h45);
    chk_eq("R9 irq for 0x31", int'(irq_out), 1);
    do_ack("R5 last vector", 1'b0, 8'h31);
    do_eoi("R7 edge 0x31", 1'b0, 0);
  endtask

  task automatic t_empty_eoi();
    do_eoi("R10 empty eoi", 1'b0, 0);
    chk_eq("R10 ppr unchanged", int'(ppr_out), 0);
    chk_eq("R10 irq low", int'(irq_out), 0);
  endtask

  task automatic t_task_priority();
    do_wr(1'b0, 16'h0150);
    chk_eq("R8 tpr low byte", int'(ppr_out), 8'h50);
    do_req(8'h52, 1'b0);
    chk_eq("R4 same class as tpr", int'(irq_out), 0);
    do_req(8'h61, 1'b0);
    chk_eq("R4 higher class passes", int'(irq_out), 1);
    do_ack("R5 above tpr", 1'b0, 8'h61);
    chk_eq("R2 isr class over tpr", int'(ppr_out), 8'h60);
    do_eoi("R7 edge 0x61", 1'b0, 0);
    chk_eq("R2 back to tpr", int'(ppr_out), 8'h50);
    chk_eq("R4 0x52 still blocked", int'(irq_out), 0);
    do_wr(1'b0, 16'h0000);
    chk_eq("R9 irq after tpr drop", int'(irq_out), 1);
    do_ack("R5 0x52", 1'b0, 8'h52);
    do_eoi("R7 edge 0x52", 1'b0, 0);
  endtask

  task automatic t_suppress_and_trigger();
    do_wr(1'b1, 16'h11F0);
    do_req(8'h90, 1'b1);
    do_ack("R5 0x90", 1'b0, 8'h90);
    do_eoi("R7 suppressed", 1'b0, 0);
    do_ack("R8 spurious F0", 1'b1, 8'hF0);
    do_wr(1'b1, 16'hE1F3);
    do_req(8'h90, 1'b1);
    do_ack("R5 0x90 again", 1'b0, 8'h90);
    do_eoi("R7 unsuppressed", 1'b1, 8'h90);
    do_ack("R8 spurious F3", 1'b1, 8'hF3);
    do_req(8'hA0, 1'b1);
    do_req(8'hA0, 1'b0);
    do_ack("R6 0xA0", 1'b0, 8'hA0);
    do_eoi("R6 latest edge wins", 1'b0, 0);
  endtask

  // Reference model for a random sequence of requests, acks, retires and tpr writes.
  logic [255:0] m_irr, m_isr, m_tmr;
  logic [7:0]   m_tpr;

  function automatic int m_hi(input logic [255:0] b);
    int r = -1;
    for (int i = 0; i < 256; i++) if (b[i]) r = i;
    return r;
  endfunction

  function automatic int m_ppr();
    int iv = m_hi(m_isr);
    if (iv < 0) iv = 0;
    return (m_tpr[7:4] >= iv[7:4]) ? int'(m_tpr) : ((iv >> 4) << 4);
  endfunction

  function automatic bit m_deliver();
    int rv = m_hi(m_irr);
    int p  = m_ppr();
    if (rv < 0) return 1'b0;
    return !(p != 0 && (rv >> 4) <= (p >> 4));
  endfunction

  task automatic t_random();
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0;
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) begin
        logic [7:0] v = 8'($urandom);
        logic l = 1'($urandom);
        do_req(v, l);
        m_irr[v] = 1'b1; m_tmr[v] = l;
      end else if (op < 7) begin
        if (m_deliver()) begin
          int v = m_hi(m_irr);
          do_ack("R5 random ack", 1'b0, v);
          m_irr[v] = 1'b0; m_isr[v] = 1'b1;
        end else begin
          do_ack("R4 random spurious", 1'b1, 8'hF3);
        end
      end else if (op < 9) begin
        int v = m_hi(m_isr);
        if (v >= 0) begin
          do_eoi("R7 random retire", m_tmr[v], v);
          m_isr[v] = 1'b0;
        end else begin
          do_eoi("R10 random empty", 1'b0, 0);
        end
      end else begin
        logic [7:0] t = 8'($urandom);
        do_wr(1'b0, {8'h00, t});
        m_tpr = t;
      end
      chk_eq("R2 random ppr", int'(ppr_out), m_ppr());
      chk_eq("R9 random irq", int'(irq_out), int'(m_deliver()));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_and_nest();
    t_empty_eoi();
    t_task_priority();
    t_suppress_and_trigger();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule